// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a serial bit stream, one bit per accepted clock cycle, and raises one detect pulse whenever the four most recently accepted bits form either `1001` or `1111`. In both patterns the leftmost bit is the one received first. Matches may share bits. This holds for repeats of one pattern and for a tail of one pattern that starts the other. A `bitValid` qualifier gates the stream, so idle cycles can be inserted anywhere without breaking a partial match.

One state machine tracks the longest tail of the accepted bits that is still a head of either pattern. A small output stage registers the result, so detect rises in the cycle after the completing bit is accepted and stays high for one clock. Two flags say which pattern completed. Both patterns are fixed when the design is built.

Top module: `twin_pattern_detector`

## Requirements
- R1: When the last four accepted bits are 1001 (first-received bit leftmost), `detect` and `flagA` are high in the cycle after the fourth bit's accepting edge. Four accepted bits 0001 give no detection.
- R2: When the last four accepted bits are 1111, `detect` and `flagB` are high in the cycle after the fourth bit's accepting edge.
- R3: Matches of the same pattern may overlap. An accepted run of 1111 followed by 1 detects at both the fourth and the fifth bit, and 1001001 detects at the fourth and the seventh bit.
- R4: Matches of different patterns may overlap. 1111001 detects 1111 at bit 4 and 1001 at bit 7, and 1001111 detects 1001 at bit 4 and 1111 at bit 7.
- R5: `detect` is high for exactly one clock per completed match. It is low in any cycle that does not follow an accepting edge that completed a match.
- R6: An edge with `bitValid` low consumes no bit. The partial match is kept across any number of such edges, and no detection follows them.
- R7: Synchronous active-high `rst` has priority over input. After a reset edge `detect`, `flagA` and `flagB` are low, and no partial match from before the reset counts toward a later match.
- R8: `flagA` marks a 1001 match and `flagB` marks a 1111 match. They are never high together, and `detect` equals their OR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | High when `bitIn` carries a bit to consume this edge |
| bitIn | input | 1 | Serial data bit |
| detect | output | 1 | One-cycle pulse after either pattern completes |
| flagA | output | 1 | One-cycle pulse after 1001 completes |
| flagB | output | 1 | One-cycle pulse after 1111 completes |

## Verification
The assertions assume that `bitValid` and `bitIn` are settled at each rising edge and that `rst` is high at the first edge. This lets the output-register rules be judged from the first clock on. The bench drives every input at the falling edge and holds reset through the opening cycles, so both assumptions hold. The bench also mixes idle cycles into the stream with arbitrary `bitIn` values. This tests that the properties about unqualified edges do not depend on the data pin being quiet.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  // Longest tail of accepted bits that is also a head of 1001 or 1111
  typedef enum logic [2:0] {
    ST_NONE = 3'd0,  // no useful tail
    ST_H1   = 3'd1,  // "1"
    ST_H10  = 3'd2,  // "10"
    ST_H100 = 3'd3,  // "100"
    ST_H11  = 3'd4,  // "11"
    ST_H111 = 3'd5   // "111"
  } trackState_t;

  // Strobes from control to the output stage
  typedef struct packed {
    logic hitA;   // accepted bit completes 1001
    logic hitB;   // accepted bit completes 1111
  } ctrlStrobe_t;

endpackage

// File: rtl/seqdet_ctrl.sv
module seqdet_ctrl
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        bitValid,
  input  logic        bitIn,
  output ctrlStrobe_t strobe
);

  trackState_t curState;
  trackState_t nextState;

  always_ff @(posedge clk) begin
    if (rst) curState <= ST_NONE;
    else     curState <= nextState;
  end

  // Transition on an accepted bit; hold otherwise
  always_comb begin
    nextState = curState;
    if (bitValid) begin
      unique case (curState)
        ST_NONE: nextState = bitIn ? ST_H1   : ST_NONE;
        ST_H1:   nextState = bitIn ? ST_H11  : ST_H10;
        ST_H10:  nextState = bitIn ? ST_H1   : ST_H100;
        ST_H100: nextState = bitIn ? ST_H1   : ST_NONE;  // 1001 -> tail "1"
        ST_H11:  nextState = bitIn ? ST_H111 : ST_H10;
        ST_H111: nextState = bitIn ? ST_H111 : ST_H10;   // 1111 -> tail "111"
        default: nextState = ST_NONE;
      endcase
    end
  end

  always_comb begin
    strobe.hitA = bitValid && bitIn && (curState == ST_H100);
    strobe.hitB = bitValid && bitIn && (curState == ST_H111);
  end

endmodule

// File: rtl/seqdet_outreg.sv
module seqdet_outreg
  import seqdet_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  ctrlStrobe_t strobe,
  output logic        detect,
  output logic        flagA,
  output logic        flagB
);

  always_ff @(posedge clk) begin
    if (rst) begin
      detect <= 1'b0;
      flagA  <= 1'b0;
      flagB  <= 1'b0;
    end else begin
      detect <= strobe.hitA | strobe.hitB;
      flagA  <= strobe.hitA;
      flagB  <= strobe.hitB;
    end
  end

endmodule

// File: rtl/twin_pattern_detector.sv
module twin_pattern_detector
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bitValid,
  input  logic bitIn,
  output logic detect,
  output logic flagA,
  output logic flagB
);

  ctrlStrobe_t strobe;

  seqdet_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .bitValid (bitValid),
    .bitIn    (bitIn),
    .strobe   (strobe)
  );

  seqdet_outreg u_out (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .detect (detect),
    .flagA  (flagA),
    .flagB  (flagB)
  );

endmodule

// File: rtl/seqdet_chk.sv
module seqdet_chk (
  input logic clk,
  input logic rst,
  input logic bitValid,
  input logic bitIn,
  input logic detect,
  input logic flagA,
  input logic flagB
);

  // R7: a reset edge leaves all outputs low
  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (!detect && !flagA && !flagB));

  // R6: an unqualified edge never produces a detection
  p_idle_no_hit_r6: assert property (@(posedge clk) disable iff (rst)
    !bitValid |=> !detect);

  // R1/R2: any detection follows an accepted one bit
  p_hit_needs_one_r1: assert property (@(posedge clk) disable iff (rst)
    detect |-> $past(bitValid && bitIn));

  // R8: the flags never fire together
  p_flags_exclusive_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flagA, flagB}));

  // R8: detect is the OR of the flags
  p_detect_or_r8: assert property (@(posedge clk) disable iff (rst)
    detect == (flagA || flagB));

  // R5: the 1001 pattern cannot complete on two consecutive bits
  p_a_single_r5: assert property (@(posedge clk) disable iff (rst)
    flagA |=> !flagA);

endmodule

bind twin_pattern_detector seqdet_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .bitValid (bitValid),
  .bitIn    (bitIn),
  .detect   (detect),
  .flagA    (flagA),
  .flagB    (flagB)
);

// File: tb/sim_twin_pattern_detector.sv
`timescale 1ns/1ps
module sim_twin_pattern_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic bitIn = 1'b0;
  logic detect, flagA, flagB;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  twin_pattern_detector u0 (
    .clk(clk), .rst(rst), .bitValid(bitValid), .bitIn(bitIn),
    .detect(detect), .flagA(flagA), .flagB(flagB)
  );

  // Each entry: {bitValid, bitIn, expected flagA, expected flagB}
  localparam int NVEC = 33;
  localparam logic [3:0] VEC [NVEC] = '{
    4'b1100, 4'b1000, 4'b1000, 4'b1110,            // 1001 -> A (R1)
    4'b1000, 4'b1000, 4'b1110,                     // 001 -> A again (R3)
    4'b1100, 4'b1100, 4'b1101, 4'b1101,            // 1111, 11111 (R2,R3)
    4'b1000, 4'b1000, 4'b1110,                     // 1111001 -> A (R4)
    4'b1100, 4'b1100, 4'b1101,                     // 1001111 -> B (R4)
    4'b0000, 4'b0100, 4'b1000, 4'b0100,            // gaps (R6)
    4'b1000, 4'b0000, 4'b1110,                     // 1 0 0 1 across gaps -> A (R6)
    4'b1000, 4'b1100, 4'b1000, 4'b1000, 4'b1110,   // 101001 -> A (R1)
    4'b1000, 4'b1000, 4'b1000, 4'b1100             // 10001 -> none (R1)
  };

  task automatic drive(input logic v, input logic b, input logic r);
    @(negedge clk);
    bitValid = v;
    bitIn    = b;
    rst      = r;
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input logic eA, input logic eB, input string req);
    checks++;
    if (detect !== (eA | eB) || flagA !== eA || flagB !== eB) begin
      errors++;
      $display("FAIL %s: got detect=%b flagA=%b flagB=%b expected detect=%b flagA=%b flagB=%b",
               req, detect, flagA, flagB, eA | eB, eA, eB);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    expect_out(1'b0, 1'b0, "R7 reset state");

    // Table walk
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][3], VEC[i][2], 1'b0);
      expect_out(VEC[i][1], VEC[i][0], "R1-table");
    end

    // R5: the pulse lasts one clock even when idle cycles follow
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    expect_out(1'b1, 1'b0, "R5 pulse high");
    drive(1'b0, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, "R5 pulse drops");

    // R7: a reset clears a partial match of 1001
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b0, 1'b0, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, "R7 partial 100 cleared");

    // R7: reset wins over a completing bit
    drive(1'b1, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b1);
    expect_out(1'b0, 1'b0, "R7 reset over completing bit");
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    expect_out(1'b0, 1'b0, "R7 three ones after reset");
    drive(1'b1, 1'b1, 1'b0);
    expect_out(1'b0, 1'b1, "R2 fourth one after reset");

    // R6: a long idle stretch keeps the partial 111
    drive(1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    drive(1'b1, 1'b1, 1'b0);
    for (int k = 0; k < 20; k++) begin
      drive(1'b0, k[0], 1'b0);
    end
    expect_out(1'b0, 1'b0, "R6 idle no detect");
    drive(1'b1, 1'b1, 1'b0);
    expect_out(1'b0, 1'b1, "R6 state kept across idle");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule